// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Read Responder

This block plays the memory side of a three-wire serial EEPROM link (select, serial clock, data in, data out) for the read command only. While select is high it watches the data-in line on each rising serial-clock edge. It waits for a first 1, which is taken as the start bit. It then takes in a two-bit command code and an address, most significant bit first. If the command is a read, it drives a single 0 and then streams 16-bit words, most significant bit first, from an internal register file. Each new output bit appears on a rising serial-clock edge.

As long as the serial clock keeps running, the address steps up by one after every word and wraps to zero past the top of the array. No further leading 0 is inserted between words. The address field width and the number of address bits that select a word are both parameters. An 8-bit field can therefore serve a 128-word array, with its top bit ignored. If the previous command was a write, the data-out line shows the programming state (1 = ready) while the block waits for a start bit. The serial pins are sampled by a fast system clock. The register file is loaded through a direct write port.

Top module: `uwire_rd_resp`

## Requirements
- R1: The output enable `do_oe_o` is 0 after reset and becomes 0 within one system clock whenever `cs_i` is low.
- R2: While `cs_i` is high and no frame is active, 0 bits on `di_i` are ignored. The first 1 sampled on a rising `sk_i` edge is the start bit.
- R3: The two bits after the start bit are the command code. Code 2'b10 (first bit 1, then 0) is a read. Any other code keeps `do_oe_o` at 0 until `cs_i` goes low.
- R4: After a read code, FLD_W address bits are taken in, most significant first. Only the low ARR_W bits select the word; any higher field bits are ignored.
- R5: On the rising edge that samples the last address bit, the block starts driving (`do_oe_o`=1) with `do_o`=0. This is the single leading 0 bit.
- R6: Each following rising `sk_i` edge puts out the next data bit, D15 first and D0 last. `do_o` changes only on rising edges.
- R7: The rising edge after D0 puts out D15 of the word at the next address, with no leading 0 in between.
- R8: After the word at the highest address (2^ARR_W - 1), reading continues at address 0.
- R9: With `cs_i` high and before a start bit, `do_oe_o` equals `prev_wr_i`. While it drives, `do_o` is the inverse of `busy_i` (1 = ready).
- R10: `do_oe_o` is 0 while the command code and address bits are being received.
- R11: Dropping `cs_i` in the middle of a frame abandons it. The next frame is decoded from its own start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock |
| di_i | input | 1 | Serial data in |
| prev_wr_i | input | 1 | Previous command was a write |
| busy_i | input | 1 | Programming still in progress |
| bd_we_i | input | 1 | Direct write enable for the register file |
| bd_addr_i | input | ARR_W | Direct write address |
| bd_data_i | input | 16 | Direct write data |
| do_o | output | 1 | Serial data out value |
| do_oe_o | output | 1 | Serial data out drive enable (0 = high impedance) |

## Verification
The hardest case to reach is the handover between words at the top of the array. There, D0 of the last word must be followed straight away by D15 of word 0. No leading 0 may come between them, and the bit index and the address must both reload on the same edge. The stimulus reaches it with table entries that start one or two words below the top and keep the clock running across the boundary. One of these entries also sets the ignored top field bit. Separate directed frames cut select in mid-word, send an invalid command code, and change the busy input while the ready level is being shown.

// File: rtl/uwr_pkg.sv
package uwr_pkg;

    localparam int unsigned WORD_W = 16;

    typedef enum logic [2:0] {
        ST_WAIT = 3'd0,
        ST_CODE = 3'd1,
        ST_ADDR = 3'd2,
        ST_DATA = 3'd3,
        ST_SKIP = 3'd4
    } rd_state_e;

endpackage

// File: rtl/uwr_sk_edge.sv
module uwr_sk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sk_i,
    output logic rise_o
);
    logic sk_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sk_q <= 1'b0;
        else        sk_q <= sk_i;
    end

    assign rise_o = sk_i & ~sk_q;
endmodule

// File: rtl/uwr_regfile.sv
module uwr_regfile #(
    parameter int unsigned AW = 6,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/uwire_rd_resp.sv
module uwire_rd_resp #(
    parameter int unsigned FLD_W = 6,
    parameter int unsigned ARR_W = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_i,
    input  logic                       sk_i,
    input  logic                       di_i,
    input  logic                       prev_wr_i,
    input  logic                       busy_i,
    input  logic                       bd_we_i,
    input  logic [ARR_W-1:0]           bd_addr_i,
    input  logic [uwr_pkg::WORD_W-1:0] bd_data_i,
    output logic                       do_o,
    output logic                       do_oe_o
);
    import uwr_pkg::*;

    localparam int unsigned CNT_W = $clog2(FLD_W + 2);
    localparam int unsigned BI_W  = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(FLD_W - 1);
    localparam logic [BI_W-1:0]  TOP_BIT   = BI_W'(WORD_W - 1);

    typedef struct packed {
        rd_state_e         st;
        logic [1:0]        code;
        logic [CNT_W-1:0]  cnt;
        logic [FLD_W-1:0]  sh;
        logic [ARR_W-1:0]  addr;
        logic [BI_W-1:0]   bidx;
        logic              dout;
        logic              oe;
    } ctl_t;

    ctl_t              ctl_d, ctl_q;
    logic              sk_rise;
    logic [WORD_W-1:0] rdata;
    logic [FLD_W-1:0]  sh_nxt;
    logic [1:0]        code_nxt;
    rd_state_e         st_q;

    uwr_sk_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sk_i   (sk_i),
        .rise_o (sk_rise)
    );

    uwr_regfile #(.AW(ARR_W), .DW(WORD_W)) u_rf (
        .clk     (clk),
        .we_i    (bd_we_i),
        .waddr_i (bd_addr_i),
        .wdata_i (bd_data_i),
        .raddr_i (ctl_q.addr),
        .rdata_o (rdata)
    );

    assign sh_nxt   = {ctl_q.sh[FLD_W-2:0], di_i};
    assign code_nxt = {ctl_q.code[0], di_i};

    always_comb begin
        ctl_d = ctl_q;
        if (!cs_i) begin
            ctl_d.st   = ST_WAIT;
            ctl_d.cnt  = '0;
            ctl_d.oe   = 1'b0;
            ctl_d.dout = 1'b0;
        end else begin
            unique case (ctl_q.st)
                ST_WAIT: begin
                    ctl_d.oe   = prev_wr_i;
                    ctl_d.dout = ~busy_i;
                    if (sk_rise && di_i) begin
                        ctl_d.st   = ST_CODE;
                        ctl_d.cnt  = '0;
                        ctl_d.oe   = 1'b0;
                        ctl_d.dout = 1'b0;
                    end
                end
                ST_CODE: begin
                    if (sk_rise) begin
                        ctl_d.code = code_nxt;
                        ctl_d.cnt  = ctl_q.cnt + 1'b1;
                        if (ctl_q.cnt[0]) begin
                            ctl_d.cnt = '0;
                            ctl_d.st  = (code_nxt == 2'b10) ? ST_ADDR : ST_SKIP;
                        end
                    end
                end
                ST_ADDR: begin
                    if (sk_rise) begin
                        ctl_d.sh = sh_nxt;
                        if (ctl_q.cnt == LAST_ADDR) begin
                            ctl_d.st   = ST_DATA;
                            ctl_d.addr = sh_nxt[ARR_W-1:0];
                            ctl_d.bidx = TOP_BIT;
                            ctl_d.oe   = 1'b1;
                            ctl_d.dout = 1'b0;
                        end else begin
                            ctl_d.cnt = ctl_q.cnt + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (sk_rise) begin
                        ctl_d.dout = rdata[ctl_q.bidx];
                        if (ctl_q.bidx == '0) begin
                            ctl_d.bidx = TOP_BIT;
                            ctl_d.addr = ctl_q.addr + 1'b1;
                        end else begin
                            ctl_d.bidx = ctl_q.bidx - 1'b1;
                        end
                    end
                end
                default: begin
                    ctl_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.st   <= ST_WAIT;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign st_q    = ctl_q.st;
    assign do_o    = ctl_q.dout;
    assign do_oe_o = ctl_q.oe;
endmodule

// File: rtl/uwr_rd_chk.sv
module uwr_rd_chk (
    input logic               clk,
    input logic               rst_n,
    input logic               cs_i,
    input logic               sk_rise,
    input uwr_pkg::rd_state_e st_q,
    input logic               do_o,
    input logic               do_oe_o
);
    import uwr_pkg::*;

    // R1
    cs_low_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_i |=> !do_oe_o);

    // R10
    frame_in_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CODE || st_q == ST_ADDR) |-> !do_oe_o);

    // R3
    bad_code_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SKIP) |-> !do_oe_o);

    // R5
    lead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(do_oe_o) && st_q == ST_DATA) |-> !do_o);

    // R6
    out_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_i && st_q != ST_WAIT && !sk_rise) |=> ($stable(do_o) && $stable(do_oe_o)));
endmodule

bind uwire_rd_resp uwr_rd_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_i    (cs_i),
    .sk_rise (sk_rise),
    .st_q    (st_q),
    .do_o    (do_o),
    .do_oe_o (do_oe_o)
);

// File: tb/uwire_rd_resp_tb_top.sv
module uwire_rd_resp_tb_top;
    localparam int unsigned FLD = 8;
    localparam int unsigned ARR = 7;
    localparam int unsigned NW  = 1 << ARR;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic prev_wr = 1'b0, busy = 1'b0;
    logic bd_we = 1'b0;
    logic [ARR-1:0] bd_addr = '0;
    logic [15:0] bd_data = '0;
    logic dout, doe;

    int checks = 0;
    int fails = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    uwire_rd_resp #(.FLD_W(FLD), .ARR_W(ARR)) dut_i (
        .clk (clk), .rst_n (rst_n), .cs_i (cs), .sk_i (sk), .di_i (di),
        .prev_wr_i (prev_wr), .busy_i (busy), .bd_we_i (bd_we),
        .bd_addr_i (bd_addr), .bd_data_i (bd_data),
        .do_o (dout), .do_oe_o (doe)
    );

    // {address field, words to read, leading zeros before start bit}
    localparam logic [23:0] VEC [5] = '{
        {8'h05, 8'd1, 8'd0},   // R4 R6 plain word
        {8'h85, 8'd1, 8'd2},   // R2 R4 top field bit ignored
        {8'h10, 8'd3, 8'd1},   // R7 streaming
        {8'h7F, 8'd2, 8'd0},   // R8 wrap 127 -> 0
        {8'hFE, 8'd3, 8'd3}    // R8 R7 wrap mid-stream
    };

    function automatic logic [15:0] exp_word(input int a);
        logic [15:0] p;
        p = 16'(a * 16'h0B3D);
        return p ^ 16'h5A96;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic b);
        di = b;
        sk = 1'b0;
        waitc(4);
        sk = 1'b1;
        waitc(4);
        sk = 1'b0;
    endtask

    task automatic send_hdr(input int lz, input logic [1:0] code, input logic [FLD-1:0] a);
        cs = 1'b1;
        waitc(2);
        for (int i = 0; i < lz; i++) pulse(1'b0);
        pulse(1'b1);
        pulse(code[1]);
        pulse(code[0]);
        for (int i = FLD - 1; i >= 0; i--) pulse(a[i]);
    endtask

    task automatic read_words(input int a0, input int n);
        logic [15:0] w;
        for (int k = 0; k < n; k++) begin
            for (int b = 15; b >= 0; b--) begin
                pulse(1'b0);
                w[b] = dout;
            end
            check("R6/R7/R8 word", w, exp_word((a0 + k) % NW));
        end
    endtask

    task automatic end_frame();
        cs = 1'b0;
        waitc(2);
        check("R1 hi-Z after select low", 16'(doe), 16'd0);
    endtask

    initial begin
        waitc(3);
        for (int a = 0; a < NW; a++) begin
            bd_we = 1'b1;
            bd_addr = ARR'(a);
            bd_data = exp_word(a);
            waitc(1);
        end
        bd_we = 1'b0;
        rst_n = 1'b1;
        waitc(2);
        check("R1 reset state", 16'(doe), 16'd0);

        // table walk
        for (int v = 0; v < 5; v++) begin
            send_hdr(int'(VEC[v][7:0]), 2'b10, VEC[v][23:16]);
            check("R5 leading zero", {14'd0, doe, dout}, 16'b10);
            read_words(int'(VEC[v][23:16]) % NW, int'(VEC[v][15:8]));
            end_frame();
        end

        // R10: no drive during code/address bits
        cs = 1'b1;
        waitc(2);
        pulse(1'b1);
        pulse(1'b1);
        check("R10 hi-Z in code", 16'(doe), 16'd0);
        pulse(1'b0);
        pulse(1'b1);
        check("R10 hi-Z in address", 16'(doe), 16'd0);
        end_frame();

        // R9 ready status
        prev_wr = 1'b1;
        busy = 1'b0;
        cs = 1'b1;
        waitc(3);
        check("R9 ready level", {14'd0, doe, dout}, 16'b11);
        busy = 1'b1;
        waitc(3);
        check("R9 busy level", {14'd0, doe, dout}, 16'b10);
        busy = 1'b0;
        pulse(1'b0);
        check("R9 R2 zero keeps ready", {14'd0, doe, dout}, 16'b11);
        pulse(1'b1);
        check("R9 R10 hi-Z after start", 16'(doe), 16'd0);
        end_frame();
        prev_wr = 1'b0;
        cs = 1'b1;
        waitc(3);
        check("R9 no write before, hi-Z", 16'(doe), 16'd0);
        end_frame();

        // R3 non-read code
        send_hdr(0, 2'b11, 8'h05);
        begin
            logic seen;
            seen = doe;
            for (int i = 0; i < 12; i++) begin
                pulse(1'b0);
                seen = seen | doe;
            end
            check("R3 other code stays hi-Z", 16'(seen), 16'd0);
        end
        end_frame();

        // R11 abort mid-word then fresh frame
        send_hdr(0, 2'b10, 8'h03);
        for (int i = 0; i < 5; i++) pulse(1'b0);
        end_frame();
        send_hdr(1, 2'b10, 8'h09);
        check("R11 leading zero after abort", {14'd0, doe, dout}, 16'b10);
        read_words(9, 1);
        end_frame();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule